// File: doc/BRIEF.md
# Synchronous Exception Detection and Entry Sequencer

This block sits next to the execute stage of a small processor. The execute stage reports each instruction as it retires. With it comes a handful of class flags: undefined or badly encoded, unconditional trap with a 4-bit handler index, trap on overflow, and unsigned divide with a flag for a zero divisor. The block decides whether the instruction starts a synchronous exception. It picks the single winning cause and then supplies the handler vector number, the program counter value to save, and the status values to install on handler entry. On entry the trace bit is cleared and the interrupt mask level is kept.

The same block decides when asynchronous requests are accepted. These are non-maskable and external interrupts, internal peripheral interrupts, trace and address error, all merged by an outside priority controller into one request line. Acceptance happens only at instruction boundaries. It is held off for exactly one instruction after any of the five status-writing instructions. A request that is pending when an exception-causing instruction retires is taken as soon as the entry sequence of that exception finishes.

Top module: `exc_seq_top`

## Requirements
- R1: An instruction retiring with `cls_invalid` set raises `exc_start` in the next cycle, with `exc_vector` = VEC_INVALID (default 4) and `exc_push_pc` = `cur_pc` of that instruction.
- R2: An unconditional trap raises `exc_start` in the next cycle, with `exc_vector` = VEC_TRAP_BASE (default 32) plus the 4-bit `trap_idx`, giving 16 contiguous vectors. `exc_push_pc` = `next_pc`.
- R3: An overflow trap raises `exc_start` with `exc_vector` = VEC_TRAPV (default 9) and `exc_push_pc` = `next_pc` only when `flag_v` is 1. With `flag_v` = 0 no exception starts.
- R4: An unsigned divide with `divisor_zero` = 1 raises `exc_start` with `exc_vector` = VEC_ZDIV (default 10) and `exc_push_pc` = `next_pc`. With a nonzero divisor no exception starts.
- R5: When several causes are flagged on one instruction, invalid wins over zero divide, and zero divide wins over trap. Exactly one `exc_start` pulse results.
- R6: During an entry, `exc_new_t` is 0 and `exc_new_imask` equals `sr_imask` as presented with the retiring instruction.
- R7: An entry sequence lasts ENTRY_CYCLES cycles (default 4), counted from the `exc_start` cycle. `instr_valid` is ignored throughout, so no further exception or interrupt starts from it.
- R8: If `async_req` is 1 when an exception-causing instruction retires, `int_start` pulses in the first cycle after the entry sequence, which is ENTRY_CYCLES cycles after `exc_start`.
- R9: If `async_req` is 1 when an instruction retires with no exception and no deferral, `int_start` pulses in the next cycle.
- R10: A status-writing instruction (`cls_ctl_write`) that retires without an exception drives `int_ok` low and suppresses `int_start` for a request present at its retirement. The next retiring instruction clears the hold, and a request at that retirement is accepted.
- R11: After reset, `exc_start` and `int_start` are 0 and `int_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| cls_invalid | input | 1 | Undefined opcode or illegal addressing mode |
| cls_trap | input | 1 | Unconditional trap instruction |
| trap_idx | input | 4 | Handler index of the unconditional trap |
| cls_trap_ovf | input | 1 | Trap-on-overflow instruction |
| flag_v | input | 1 | Current overflow flag |
| cls_divu | input | 1 | Unsigned divide instruction |
| divisor_zero | input | 1 | Divisor operand is zero |
| cls_ctl_write | input | 1 | One of the five status-writing instructions |
| cur_pc | input | PC_W | Address at which the instruction was detected |
| next_pc | input | PC_W | Address of the following instruction |
| sr_t | input | 1 | Current trace bit |
| sr_imask | input | 3 | Current interrupt mask level |
| async_req | input | 1 | Merged asynchronous request from the priority controller |
| exc_start | output | 1 | One-cycle synchronous exception start strobe |
| exc_vector | output | 8 | Handler vector number |
| exc_push_pc | output | PC_W | Program counter value to save |
| exc_new_t | output | 1 | Trace bit to install |
| exc_new_imask | output | 3 | Mask level to install |
| int_start | output | 1 | One-cycle asynchronous acceptance strobe |
| int_ok | output | 1 | Acceptance window open (low while deferring or sequencing) |

## Verification
Several rules are checked on every cycle. An entry never starts in two consecutive cycles. Every entry carries a cleared trace bit and the mask level sampled at retirement. An overflow trap with V clear, or a divide by a nonzero value, never starts an entry. The exception and interrupt strobes never coincide. After a status-writing instruction retires, the acceptance window is closed in the next cycle. The scenarios are needed for the exact vector numbers of each cause, for the priority among simultaneous causes, and for the cycle on which a deferred or queued interrupt is finally accepted after an entry sequence. They also show that an instruction presented in mid-sequence leaves no trace.

// File: rtl/exc_seq_pkg.sv
// Shared definitions for the exception sequencer.
// Assumes: vectors are 8 bits wide; the cause set is fixed.
package exc_seq_pkg;
    localparam int VEC_W = 8;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_INVALID = 3'd1,
        CAUSE_ZDIV    = 3'd2,
        CAUSE_TRAP    = 3'd3,
        CAUSE_TRAPV   = 3'd4
    } exc_cause_e;
endpackage

// File: rtl/exc_classify.sv
// Combinational cause selection for one retiring instruction.
// Priority: invalid > zero divide > trap (unconditional before overflow).
// Assumes: flags are only meaningful while an instruction retires; the
// caller qualifies hit with its own retire signal.
module exc_classify
    import exc_seq_pkg::*;
#(
    parameter int                PC_W          = 16,
    parameter logic [VEC_W-1:0]  VEC_INVALID   = 8'd4,
    parameter logic [VEC_W-1:0]  VEC_ZDIV      = 8'd10,
    parameter logic [VEC_W-1:0]  VEC_TRAPV     = 8'd9,
    parameter logic [VEC_W-1:0]  VEC_TRAP_BASE = 8'd32
) (
    input  logic              cls_invalid,
    input  logic              cls_trap,
    input  logic [3:0]        trap_idx,
    input  logic              cls_trap_ovf,
    input  logic              flag_v,
    input  logic              cls_divu,
    input  logic              divisor_zero,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   next_pc,
    output logic              hit,
    output logic [VEC_W-1:0]  vector,
    output logic [PC_W-1:0]   push_pc
);
    exc_cause_e cause;

    // Pick the single winning cause.
    always_comb begin
        if (cls_invalid)                 cause = CAUSE_INVALID;
        else if (cls_divu && divisor_zero) cause = CAUSE_ZDIV;
        else if (cls_trap)               cause = CAUSE_TRAP;
        else if (cls_trap_ovf && flag_v) cause = CAUSE_TRAPV;
        else                             cause = CAUSE_NONE;
    end

    // Map the cause to a vector number and the address to save.
    always_comb begin
        hit     = 1'b1;
        vector  = '0;
        push_pc = next_pc;
        unique case (cause)
            CAUSE_INVALID: begin
                vector  = VEC_INVALID;
                push_pc = cur_pc;
            end
            CAUSE_ZDIV:  vector = VEC_ZDIV;
            CAUSE_TRAP:  vector = VEC_TRAP_BASE + {{(VEC_W-4){1'b0}}, trap_idx};
            CAUSE_TRAPV: vector = VEC_TRAPV;
            default:     hit    = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_defer_window.sv
// One-instruction hold-off flag for asynchronous acceptance.
// Set when a status-writing instruction retires without an exception;
// cleared by the next retirement.
// Assumes: retire is already gated by the sequencer's busy state.
module exc_defer_window (
    input  logic clk,
    input  logic rst_n,
    input  logic retire,
    input  logic ctl_write,
    input  logic exc_hit,
    output logic defer_q
);
    // Track whether the instruction just retired opened a hold-off window.
    always_ff @(posedge clk) begin
        if (!rst_n)      defer_q <= 1'b0;
        else if (retire) defer_q <= ctl_write && !exc_hit;
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Entry sequencer: issues the exception strobe and its payload, times the
// entry sequence, and releases a queued asynchronous request after it.
// Assumes: ENTRY_CYCLES >= 1; retire is low while busy is high.
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int PC_W         = 16,
    parameter int ENTRY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  logic              exc_hit,
    input  logic [VEC_W-1:0]  vector_in,
    input  logic [PC_W-1:0]   push_pc_in,
    input  logic              sr_t,
    input  logic [2:0]        sr_imask,
    input  logic              async_req,
    input  logic              hold_take,
    output logic              exc_start,
    output logic [VEC_W-1:0]  exc_vector,
    output logic [PC_W-1:0]   exc_push_pc,
    output logic              exc_new_t,
    output logic [2:0]        exc_new_imask,
    output logic              int_start,
    output logic              busy
);
    localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENTRY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    assign busy = (cnt_q != '0);

    // Load the payload on entry, count down the sequence, release interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_start     <= 1'b0;
            exc_vector    <= '0;
            exc_push_pc   <= '0;
            exc_new_t     <= 1'b0;
            exc_new_imask <= '0;
            int_start     <= 1'b0;
            cnt_q         <= '0;
            pend_q        <= 1'b0;
        end else begin
            exc_start <= 1'b0;
            int_start <= 1'b0;
            if (retire && exc_hit) begin
                exc_start     <= 1'b1;
                exc_vector    <= vector_in;
                exc_push_pc   <= push_pc_in;
                exc_new_t     <= 1'b0;
                exc_new_imask <= sr_imask;
                cnt_q         <= CNT_LOAD;
                pend_q        <= async_req;
            end else begin
                if (busy) begin
                    cnt_q <= cnt_q - CNT_LAST;
                end else begin
                    exc_new_t     <= sr_t;
                    exc_new_imask <= sr_imask;
                end
                if (cnt_q == CNT_LAST && pend_q) begin
                    int_start <= 1'b1;
                    pend_q    <= 1'b0;
                end
                if (retire && async_req && !hold_take) int_start <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_seq_top.sv
// Top of the exception sequencer: classifies the retiring instruction,
// keeps the one-instruction hold-off window and drives the entry sequence.
// Assumes: instr_valid pulses once per retiring instruction; async_req is
// the merged output of an external priority controller.
module exc_seq_top
    import exc_seq_pkg::*;
#(
    parameter int                PC_W          = 16,
    parameter int                ENTRY_CYCLES  = 4,
    parameter logic [VEC_W-1:0]  VEC_INVALID   = 8'd4,
    parameter logic [VEC_W-1:0]  VEC_ZDIV      = 8'd10,
    parameter logic [VEC_W-1:0]  VEC_TRAPV     = 8'd9,
    parameter logic [VEC_W-1:0]  VEC_TRAP_BASE = 8'd32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              cls_invalid,
    input  logic              cls_trap,
    input  logic [3:0]        trap_idx,
    input  logic              cls_trap_ovf,
    input  logic              flag_v,
    input  logic              cls_divu,
    input  logic              divisor_zero,
    input  logic              cls_ctl_write,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              sr_t,
    input  logic [2:0]        sr_imask,
    input  logic              async_req,
    output logic              exc_start,
    output logic [VEC_W-1:0]  exc_vector,
    output logic [PC_W-1:0]   exc_push_pc,
    output logic              exc_new_t,
    output logic [2:0]        exc_new_imask,
    output logic              int_start,
    output logic              int_ok
);
    logic              seq_busy;
    logic              retire;
    logic              exc_hit;
    logic [VEC_W-1:0]  cls_vector;
    logic [PC_W-1:0]   cls_push_pc;
    logic              defer_q;

    // An instruction counts only while no entry sequence is running.
    assign retire = instr_valid && !seq_busy;
    // Acceptance window: closed while deferring or sequencing.
    assign int_ok = !defer_q && !seq_busy;

    exc_classify #(
        .PC_W(PC_W), .VEC_INVALID(VEC_INVALID), .VEC_ZDIV(VEC_ZDIV),
        .VEC_TRAPV(VEC_TRAPV), .VEC_TRAP_BASE(VEC_TRAP_BASE)
    ) classify_i (
        .cls_invalid(cls_invalid), .cls_trap(cls_trap), .trap_idx(trap_idx),
        .cls_trap_ovf(cls_trap_ovf), .flag_v(flag_v), .cls_divu(cls_divu),
        .divisor_zero(divisor_zero), .cur_pc(cur_pc), .next_pc(next_pc),
        .hit(exc_hit), .vector(cls_vector), .push_pc(cls_push_pc)
    );

    exc_defer_window defer_i (
        .clk(clk), .rst_n(rst_n), .retire(retire),
        .ctl_write(cls_ctl_write), .exc_hit(exc_hit), .defer_q(defer_q)
    );

    exc_entry_seq #(.PC_W(PC_W), .ENTRY_CYCLES(ENTRY_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .retire(retire), .exc_hit(exc_hit),
        .vector_in(cls_vector), .push_pc_in(cls_push_pc), .sr_t(sr_t),
        .sr_imask(sr_imask), .async_req(async_req), .hold_take(cls_ctl_write),
        .exc_start(exc_start), .exc_vector(exc_vector),
        .exc_push_pc(exc_push_pc), .exc_new_t(exc_new_t),
        .exc_new_imask(exc_new_imask), .int_start(int_start), .busy(seq_busy)
    );
endmodule

// File: rtl/exc_seq_checker.sv
// Property checker for exc_seq_top, attached by bind below.
module exc_seq_checker #(
    parameter int       PC_W        = 16,
    parameter logic [7:0] VEC_INVALID = 8'd4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            retire,
    input logic            busy,
    input logic            instr_valid,
    input logic            cls_invalid,
    input logic            cls_trap,
    input logic            cls_trap_ovf,
    input logic            flag_v,
    input logic            cls_divu,
    input logic            divisor_zero,
    input logic            cls_ctl_write,
    input logic [PC_W-1:0] cur_pc,
    input logic [2:0]      sr_imask,
    input logic            exc_start,
    input logic [7:0]      exc_vector,
    input logic [PC_W-1:0] exc_push_pc,
    input logic            exc_new_t,
    input logic [2:0]      exc_new_imask,
    input logic            int_start,
    input logic            int_ok
);
    logic any_cause;
    assign any_cause = cls_invalid || (cls_divu && divisor_zero) || cls_trap
                       || (cls_trap_ovf && flag_v);

    p_invalid_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && cls_invalid) |=> (exc_start && exc_vector == VEC_INVALID
                                     && exc_push_pc == $past(cur_pc)));

    p_trapv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && cls_trap_ovf && !flag_v && !cls_invalid && !cls_trap
         && !(cls_divu && divisor_zero)) |=> !exc_start);

    p_div_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && cls_divu && !divisor_zero && !cls_invalid && !cls_trap
         && !(cls_trap_ovf && flag_v)) |=> !exc_start);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |=> !exc_start);

    p_t_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |-> !exc_new_t);

    p_mask_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |-> (exc_new_imask == $past(sr_imask)));

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && busy) |=> !exc_start);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_start && int_start));

    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && cls_ctl_write && !any_cause) |=> (!int_ok && !int_start));
endmodule

bind exc_seq_top exc_seq_checker #(.PC_W(PC_W), .VEC_INVALID(VEC_INVALID)) chk_i (
    .clk(clk), .rst_n(rst_n), .retire(retire), .busy(seq_busy),
    .instr_valid(instr_valid), .cls_invalid(cls_invalid), .cls_trap(cls_trap),
    .cls_trap_ovf(cls_trap_ovf), .flag_v(flag_v), .cls_divu(cls_divu),
    .divisor_zero(divisor_zero), .cls_ctl_write(cls_ctl_write),
    .cur_pc(cur_pc), .sr_imask(sr_imask), .exc_start(exc_start),
    .exc_vector(exc_vector), .exc_push_pc(exc_push_pc),
    .exc_new_t(exc_new_t), .exc_new_imask(exc_new_imask),
    .int_start(int_start), .int_ok(int_ok)
);

// File: tb/exc_seq_top_tb_top.sv
// Scoreboard bench: driver tasks queue the expected strobes, a monitor at
// the falling edge pops and compares them.
module exc_seq_top_tb_top;
    localparam int PC_W  = 16;
    localparam int ENTRY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 0, cls_invalid = 0, cls_trap = 0, cls_trap_ovf = 0;
    logic flag_v = 0, cls_divu = 0, divisor_zero = 0, cls_ctl_write = 0;
    logic [3:0] trap_idx = '0;
    logic [PC_W-1:0] cur_pc = '0, next_pc = '0;
    logic sr_t = 0;
    logic [2:0] sr_imask = '0;
    logic async_req = 0;
    logic exc_start, exc_new_t, int_start, int_ok;
    logic [7:0] exc_vector;
    logic [PC_W-1:0] exc_push_pc;
    logic [2:0] exc_new_imask;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    string cur_req = "R11";

    typedef struct {
        int         at;
        bit         is_int;
        logic [7:0] vec;
        logic [PC_W-1:0] pc;
        logic [2:0] im;
        string      req;
    } item_t;
    item_t exp_q[$];

    exc_seq_top #(.PC_W(PC_W), .ENTRY_CYCLES(ENTRY)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .cls_invalid(cls_invalid), .cls_trap(cls_trap), .trap_idx(trap_idx),
        .cls_trap_ovf(cls_trap_ovf), .flag_v(flag_v), .cls_divu(cls_divu),
        .divisor_zero(divisor_zero), .cls_ctl_write(cls_ctl_write),
        .cur_pc(cur_pc), .next_pc(next_pc), .sr_t(sr_t), .sr_imask(sr_imask),
        .async_req(async_req), .exc_start(exc_start), .exc_vector(exc_vector),
        .exc_push_pc(exc_push_pc), .exc_new_t(exc_new_t),
        .exc_new_imask(exc_new_imask), .int_start(int_start), .int_ok(int_ok)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Compare one value and record the outcome.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare every strobe the design produces.
    always @(negedge clk) begin
        if (rst_n && (exc_start || int_start)) begin
            if (exc_start && int_start) begin
                chk("R8", "both strobes together", 1, 0);
            end else if (exp_q.size() == 0) begin
                chk(cur_req, "unexpected strobe (exc,int)",
                    {30'd0, exc_start, int_start}, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(it.req, "strobe cycle", cyc, it.at);
                chk(it.req, "strobe kind int", {31'd0, int_start}, {31'd0, it.is_int});
                if (!it.is_int && exc_start) begin
                    chk(it.req, "vector", {24'd0, exc_vector}, {24'd0, it.vec});
                    chk(it.req, "push pc", {16'd0, exc_push_pc}, {16'd0, it.pc});
                    chk("R6", "new T", {31'd0, exc_new_t}, 0);
                    chk("R6", "new imask", {29'd0, exc_new_imask}, {29'd0, it.im});
                end
            end
        end
    end

    // Present one instruction for a single cycle (no expectation queued).
    task automatic present(input logic inv, input logic trp, input logic [3:0] idx,
                           input logic tv, input logic v, input logic dv,
                           input logic dz, input logic cw, input logic [PC_W-1:0] pc,
                           input logic t, input logic [2:0] im, input logic ar);
        instr_valid = 1; cls_invalid = inv; cls_trap = trp; trap_idx = idx;
        cls_trap_ovf = tv; flag_v = v; cls_divu = dv; divisor_zero = dz;
        cls_ctl_write = cw; cur_pc = pc; next_pc = pc + 16'd2;
        sr_t = t; sr_imask = im; async_req = ar;
        @(negedge clk);
        instr_valid = 0; cls_invalid = 0; cls_trap = 0; cls_trap_ovf = 0;
        cls_divu = 0; divisor_zero = 0; cls_ctl_write = 0; async_req = 0;
    endtask

    // Driver: queue expected strobes, present the instruction, then idle.
    task automatic issue(input string req, input logic inv, input logic trp,
                         input logic [3:0] idx, input logic tv, input logic v,
                         input logic dv, input logic dz, input logic cw,
                         input logic [PC_W-1:0] pc, input logic [2:0] im,
                         input logic ar, input bit exp_exc, input logic [7:0] ev,
                         input logic [PC_W-1:0] epc, input bit exp_int);
        item_t it;
        cur_req = req;
        if (exp_exc) begin
            it = '{at: cyc + 1, is_int: 0, vec: ev, pc: epc, im: im, req: req};
            exp_q.push_back(it);
        end
        if (exp_int) begin
            it = '{at: (exp_exc ? cyc + 1 + ENTRY : cyc + 1), is_int: 1,
                   vec: 8'd0, pc: '0, im: 3'd0, req: req};
            exp_q.push_back(it);
        end
        present(inv, trp, idx, tv, v, dv, dz, cw, pc, 1'b1, im, ar);
        if (!exp_exc) chk(req, "no exception strobe", {31'd0, exc_start}, 0);
        repeat (ENTRY + 2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "exc_start after reset", {31'd0, exc_start}, 0);
        chk("R11", "int_start after reset", {31'd0, int_start}, 0);
        chk("R11", "int_ok after reset", {31'd0, int_ok}, 1);

        // R1: invalid instruction saves the detection address
        issue("R1", 1,0,4'd0, 0,0, 0,0, 0, 16'h1000, 3'd5, 0, 1, 8'd4, 16'h1000, 0);
        // R2: unconditional trap, lowest and highest index
        issue("R2", 0,1,4'd0, 0,0, 0,0, 0, 16'h1100, 3'd2, 0, 1, 8'd32, 16'h1102, 0);
        issue("R2", 0,1,4'd15, 0,0, 0,0, 0, 16'h1200, 3'd0, 0, 1, 8'd47, 16'h1202, 0);
        // R3: overflow trap with V set, then with V clear
        issue("R3", 0,0,4'd0, 1,1, 0,0, 0, 16'h1300, 3'd3, 0, 1, 8'd9, 16'h1302, 0);
        issue("R3", 0,0,4'd0, 1,0, 0,0, 0, 16'h1310, 3'd3, 0, 0, 8'd0, 16'h0, 0);
        // R4: divide by zero, then by nonzero
        issue("R4", 0,0,4'd0, 0,0, 1,1, 0, 16'h1400, 3'd1, 0, 1, 8'd10, 16'h1402, 0);
        issue("R4", 0,0,4'd0, 0,0, 1,0, 0, 16'h1410, 3'd1, 0, 0, 8'd0, 16'h0, 0);
        // R5: priority among simultaneous causes
        issue("R5", 1,1,4'd3, 1,1, 1,1, 0, 16'h1500, 3'd4, 0, 1, 8'd4, 16'h1500, 0);
        issue("R5", 0,1,4'd3, 0,0, 1,1, 0, 16'h1510, 3'd4, 0, 1, 8'd10, 16'h1512, 0);
        // R6: mask level 7 is carried, trace cleared
        issue("R6", 0,1,4'd7, 0,0, 0,0, 0, 16'h1600, 3'd7, 0, 1, 8'd39, 16'h1602, 0);

        // R7: instruction presented during the sequence is ignored
        begin
            item_t it;
            cur_req = "R7";
            it = '{at: cyc + 1, is_int: 0, vec: 8'd4, pc: 16'h1700, im: 3'd0, req: "R7"};
            exp_q.push_back(it);
            present(1,0,4'd0, 0,0, 0,0, 0, 16'h1700, 1'b0, 3'd0, 0);
            chk("R7", "int_ok low while sequencing", {31'd0, int_ok}, 0);
            present(0,1,4'd2, 0,0, 0,0, 0, 16'h1710, 1'b0, 3'd0, 1);
            repeat (ENTRY + 3) @(negedge clk);
            chk("R7", "no leftover expectations", exp_q.size(), 0);
        end

        // R8: request pending at a trap is taken right after the sequence
        issue("R8", 0,1,4'd1, 0,0, 0,0, 0, 16'h1800, 3'd2, 1, 1, 8'd33, 16'h1802, 1);
        issue("R8", 0,0,4'd0, 0,0, 1,1, 0, 16'h1810, 3'd2, 1, 1, 8'd10, 16'h1812, 1);
        // R9: request at a plain instruction is taken next cycle
        issue("R9", 0,0,4'd0, 0,0, 0,0, 0, 16'h1900, 3'd0, 1, 0, 8'd0, 16'h0, 1);

        // R10: status-writing instruction holds off for one instruction
        cur_req = "R10";
        present(0,0,4'd0, 0,0, 0,0, 1, 16'h1A00, 1'b0, 3'd0, 1);
        chk("R10", "int_ok after status write", {31'd0, int_ok}, 0);
        chk("R10", "int_start after status write", {31'd0, int_start}, 0);
        @(negedge clk);
        chk("R10", "int_ok still held", {31'd0, int_ok}, 0);
        issue("R10", 0,0,4'd0, 0,0, 0,0, 0, 16'h1A02, 3'd0, 1, 0, 8'd0, 16'h0, 1);
        chk("R10", "int_ok reopened", {31'd0, int_ok}, 1);

        chk("R5", "queue drained", exp_q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule